// File: doc/BRIEF.md
# Audio Port Interrupt Flag Register

This block is the interrupt status unit of a double-buffered audio serial port. Six event and error conditions are gathered into a 32-bit flags word that software reads through a small register port. The four error conditions are sticky: each stays set until software writes a 1 to the same bit position of a separate clear register. The two buffer-ready events work differently. Each one clears itself when software loads the matching next-block pointer.

The block also holds the two next-block pointers, one for capture and one for playback. Each pointer has a valid bit. A write to the pointer sets the valid bit. When the DMA engine signals a block boundary, a valid pointer moves to the active-pointer output and its valid bit clears. If a boundary arrives while the valid bit is 0, the block raises the pointer error. A mask register selects which flags drive the single combined interrupt line.

The serial shifter, the clock monitor and the DMA engine sit outside this block. They deliver single-cycle strobes. The asynchronous reset input is released through a two-stage synchroniser, so the block leaves reset on the second rising clock edge after `rst_n` goes high.

Top module: `aud_irq_flags`

## Requirements
- R1: A read at address 0 returns the flags word. Bit 0 is pointer error, bit 1 is word-clock error, bit 2 is bus error, bit 3 is word-clock timeout, bit 4 is the playback (output) buffer event and bit 5 is the capture (input) buffer event. Bits 31:6 always read 0.
- R2: After reset, the flags, the mask, both next pointers, both valid bits, both active-pointer outputs and `irq_o` are all 0.
- R3: Flags bits 3:0 stay set until a write to address 1 (the clear register) carries a 1 at the same bit position. In that write, bits that are 0 leave their flags alone, and bits 5:4 have no effect.
- R4: If a set strobe and a clear act on the same flag in the same cycle, the flag ends up set.
- R5: A write to address 3 (capture next pointer) or address 4 (playback next pointer) stores the low `PTR_W` bits and sets that pointer's valid bit. Reads at those addresses return the stored pointer, zero-extended. A boundary strobe that finds the valid bit set copies the pointer to its active-pointer output and clears the valid bit.
- R6: A boundary strobe that finds its valid bit at 0 sets flag bit 0 and leaves the active-pointer output unchanged.
- R7: Every capture boundary strobe sets flag bit 5 and every playback boundary strobe sets flag bit 4. A write to address 3 clears bit 5, and a write to address 4 clears bit 4.
- R8: The word-clock error, bus error and word-clock timeout strobes set flag bits 1, 2 and 3 one cycle after the strobe.
- R9: Address 2 is a 6-bit read/write mask, read back zero-extended. `irq_o` is the OR of the flags ANDed with the mask.
- R10: Reads of address 1 and of addresses 5 to 7 return 0. Writes to addresses 5 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe of the register port |
| reg_addr | input | ADDR_W | Word address of the register port |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, combinational from `reg_addr` |
| wclk_err_stb | input | 1 | Word-clock error event |
| bus_err_stb | input | 1 | Bus deadline missed (underflow or overflow) |
| wclk_tmo_stb | input | 1 | Word-clock timeout event |
| in_blk_end | input | 1 | Capture block boundary reached |
| out_blk_end | input | 1 | Playback block boundary reached |
| in_ptr_o | output | PTR_W | Active capture block address |
| out_ptr_o | output | PTR_W | Active playback block address |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench builds the block with `PTR_W` = 8 and the default 3-bit address, so every address can be swept. For every one of the 64 clear-register patterns, it checks which sticky bits survive and confirms that the event bits are untouched. For every one of the 64 mask values, it checks the interrupt output and the mask read-back. Directed sequences cover the pointer valid bit, the pointer-miss error and same-cycle collisions between a set and a clear.

// File: rtl/aud_irq_pkg.sv
package aud_irq_pkg;
  localparam int unsigned NUM_FLAGS = 6;
  localparam int unsigned NUM_STICKY = 4;

  localparam int unsigned FB_PTR_MISS = 0;
  localparam int unsigned FB_WCLK_ERR = 1;
  localparam int unsigned FB_BUS_ERR  = 2;
  localparam int unsigned FB_WCLK_TMO = 3;
  localparam int unsigned FB_OUT_EVT  = 4;
  localparam int unsigned FB_IN_EVT   = 5;

  typedef enum logic [2:0] {
    ADR_FLAGS   = 3'd0,
    ADR_CLEAR   = 3'd1,
    ADR_MASK    = 3'd2,
    ADR_NXT_IN  = 3'd3,
    ADR_NXT_OUT = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/aud_flag_cell.sv
module aud_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_q, q_d, q_en;

  // set has priority over clear
  always_comb begin
    q_en = set_i | clr_i;
    q_d  = set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_q <= 1'b0;
    else if (q_en) q_q <= q_d;
  end

  assign q_o = q_q;
endmodule

// File: rtl/aud_ptr_slot.sv
module aud_ptr_slot #(
  parameter int unsigned PTR_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [PTR_W-1:0] wdata_i,
  input  logic             take_i,
  output logic [PTR_W-1:0] nxt_o,
  output logic [PTR_W-1:0] cur_o,
  output logic             vld_o,
  output logic             miss_o
);
  logic [PTR_W-1:0] nxt_q, cur_q;
  logic             vld_q, vld_d, vld_en;
  logic             cur_en;

  always_comb begin
    cur_en = take_i & vld_q;
    vld_en = wr_i | take_i;
    vld_d  = wr_i;
    miss_o = take_i & ~vld_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    nxt_q <= '0;
    else if (wr_i) nxt_q <= wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cur_q <= '0;
    else if (cur_en) cur_q <= nxt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      vld_q <= 1'b0;
    else if (vld_en) vld_q <= vld_d;
  end

  assign nxt_o = nxt_q;
  assign cur_o = cur_q;
  assign vld_o = vld_q;
endmodule

// File: rtl/aud_irq_flags.sv
module aud_irq_flags
  import aud_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PTR_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              wclk_err_stb,
  input  logic              bus_err_stb,
  input  logic              wclk_tmo_stb,
  input  logic              in_blk_end,
  input  logic              out_blk_end,
  output logic [PTR_W-1:0]  in_ptr_o,
  output logic [PTR_W-1:0]  out_ptr_o,
  output logic              irq_o
);
  localparam int unsigned PAD_W = DATA_W - NUM_FLAGS;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ok = rst_sync_q[1];

  // address decode
  logic wr_clear, wr_mask, wr_nxt_in, wr_nxt_out;

  always_comb begin
    wr_clear   = reg_wr & (reg_addr == ADDR_W'(ADR_CLEAR));
    wr_mask    = reg_wr & (reg_addr == ADDR_W'(ADR_MASK));
    wr_nxt_in  = reg_wr & (reg_addr == ADDR_W'(ADR_NXT_IN));
    wr_nxt_out = reg_wr & (reg_addr == ADDR_W'(ADR_NXT_OUT));
  end

  // next-block pointer slots
  logic [PTR_W-1:0] nxt_in, nxt_out;
  logic             in_vld, out_vld, in_miss, out_miss;

  aud_ptr_slot #(.PTR_W(PTR_W)) u_in_slot (
    .clk(clk), .rst_n(rst_ok), .wr_i(wr_nxt_in), .wdata_i(reg_wdata[PTR_W-1:0]),
    .take_i(in_blk_end), .nxt_o(nxt_in), .cur_o(in_ptr_o), .vld_o(in_vld),
    .miss_o(in_miss)
  );

  aud_ptr_slot #(.PTR_W(PTR_W)) u_out_slot (
    .clk(clk), .rst_n(rst_ok), .wr_i(wr_nxt_out), .wdata_i(reg_wdata[PTR_W-1:0]),
    .take_i(out_blk_end), .nxt_o(nxt_out), .cur_o(out_ptr_o), .vld_o(out_vld),
    .miss_o(out_miss)
  );

  // flag set / clear vectors
  logic [NUM_FLAGS-1:0] flag_set, flag_clr, flags_q;

  always_comb begin
    flag_set = '0;
    flag_clr = '0;
    flag_set[FB_PTR_MISS] = in_miss | out_miss;
    flag_set[FB_WCLK_ERR] = wclk_err_stb;
    flag_set[FB_BUS_ERR]  = bus_err_stb;
    flag_set[FB_WCLK_TMO] = wclk_tmo_stb;
    flag_set[FB_OUT_EVT]  = out_blk_end;
    flag_set[FB_IN_EVT]   = in_blk_end;
    flag_clr[NUM_STICKY-1:0] = wr_clear ? reg_wdata[NUM_STICKY-1:0] : '0;
    flag_clr[FB_OUT_EVT]  = wr_nxt_out;
    flag_clr[FB_IN_EVT]   = wr_nxt_in;
  end

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    aud_flag_cell u_cell (
      .clk(clk), .rst_n(rst_ok), .set_i(flag_set[g]), .clr_i(flag_clr[g]),
      .q_o(flags_q[g])
    );
  end

  // interrupt mask
  logic [NUM_FLAGS-1:0] mask_q;

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok)      mask_q <= '0;
    else if (wr_mask) mask_q <= reg_wdata[NUM_FLAGS-1:0];
  end

  assign irq_o = |(flags_q & mask_q);

  // read mux
  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_W'(ADR_FLAGS):   reg_rdata = {{PAD_W{1'b0}}, flags_q};
      ADDR_W'(ADR_MASK):    reg_rdata = {{PAD_W{1'b0}}, mask_q};
      ADDR_W'(ADR_NXT_IN):  reg_rdata = DATA_W'(nxt_in);
      ADDR_W'(ADR_NXT_OUT): reg_rdata = DATA_W'(nxt_out);
      default:              reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/aud_irq_flags_chk.sv
module aud_irq_flags_chk #(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_ok,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic [5:0]        flags_q,
  input logic [5:0]        mask_q,
  input logic              in_vld,
  input logic              out_vld,
  input logic              in_blk_end,
  input logic              out_blk_end,
  input logic              wclk_err_stb,
  input logic              irq_o
);
  logic [3:0] hold_bits;
  assign hold_bits = flags_q[3:0] &
                     ~((reg_wr && reg_addr == ADDR_W'(1)) ? reg_wdata[3:0] : 4'h0);

  // R1
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (reg_addr == ADDR_W'(0)) |-> (reg_rdata[DATA_W-1:6] == '0));

  // R3
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    1'b1 |=> ((flags_q[3:0] & $past(hold_bits)) == $past(hold_bits)));

  // R4
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    wclk_err_stb |=> flags_q[1]);

  // R5
  vld_load_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (reg_wr && reg_addr == ADDR_W'(3)) |=> in_vld);

  // R6
  ptr_miss_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    ((in_blk_end && !in_vld) || (out_blk_end && !out_vld)) |=> flags_q[0]);

  // R9
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    irq_o == |(flags_q & mask_q));
endmodule

bind aud_irq_flags aud_irq_flags_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_ok(rst_ok), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .flags_q(flags_q),
  .mask_q(mask_q), .in_vld(in_vld), .out_vld(out_vld),
  .in_blk_end(in_blk_end), .out_blk_end(out_blk_end),
  .wclk_err_stb(wclk_err_stb), .irq_o(irq_o)
);

// File: tb/tb_aud_irq_flags.sv
module tb_aud_irq_flags;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned PTR_W  = 8;
  localparam int LIMIT = 100000;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              reg_wr;
  logic [ADDR_W-1:0] reg_addr;
  logic [DATA_W-1:0] reg_wdata;
  logic [DATA_W-1:0] reg_rdata;
  logic              wclk_err_stb, bus_err_stb, wclk_tmo_stb;
  logic              in_blk_end, out_blk_end;
  logic [PTR_W-1:0]  in_ptr_o, out_ptr_o;
  logic              irq_o;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  aud_irq_flags #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PTR_W(PTR_W)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wclk_err_stb(wclk_err_stb),
    .bus_err_stb(bus_err_stb), .wclk_tmo_stb(wclk_tmo_stb),
    .in_blk_end(in_blk_end), .out_blk_end(out_blk_end),
    .in_ptr_o(in_ptr_o), .out_ptr_o(out_ptr_o), .irq_o(irq_o)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == LIMIT) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: actual=%0d cycles expected<%0d", cyc, LIMIT);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    reg_wr = 1'b0; wclk_err_stb = 1'b0; bus_err_stb = 1'b0; wclk_tmo_stb = 1'b0;
    in_blk_end = 1'b0; out_blk_end = 1'b0;
  endtask

  // inputs are set up at the negative edge, take effect at the next rising edge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    step();
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic pulse_in();  in_blk_end = 1'b1;  step(); endtask
  task automatic pulse_out(); out_blk_end = 1'b1; step(); endtask

  logic [31:0] v;

  initial begin
    idle();
    reg_addr = '0; reg_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 reset state
    rd(0, v); check("R2 flags", v, 32'h0);
    rd(2, v); check("R2 mask", v, 32'h0);
    rd(3, v); check("R2 nxt_in", v, 32'h0);
    rd(4, v); check("R2 nxt_out", v, 32'h0);
    check("R2 irq", {31'd0, irq_o}, 32'h0);
    check("R2 in_ptr", {24'd0, in_ptr_o}, 32'h0);
    check("R2 out_ptr", {24'd0, out_ptr_o}, 32'h0);

    // R10 unmapped and clear-register reads
    for (int a = 5; a < 8; a++) begin
      wr(a[ADDR_W-1:0], 32'hFFFF_FFFF);
      rd(a[ADDR_W-1:0], v); check("R10 unmapped read", v, 32'h0);
    end
    rd(0, v); check("R10 flags after unmapped write", v, 32'h0);
    rd(2, v); check("R10 mask after unmapped write", v, 32'h0);
    rd(1, v); check("R10 clear reads zero", v, 32'h0);

    // R3 R8 R1: sweep of every clear pattern
    for (int p = 0; p < 64; p++) begin
      pulse_in();            // consumes a valid pointer or misses
      pulse_in();            // valid is now 0: miss
      wclk_err_stb = 1'b1; bus_err_stb = 1'b1; wclk_tmo_stb = 1'b1;
      step();
      rd(0, v); check("R8 r1_ all flags set", v, 32'h2F);
      wr(1, p);
      rd(0, v); check("R3 after clear pattern", v, 32'h2F & ~(p & 32'hF));
      wr(1, 32'hFFFF_FFFF);
      rd(0, v); check("R3 clear leaves event bit", v, 32'h20);
      wr(3, p);
      rd(0, v); check("R7 in event cleared by pointer write", v, 32'h0);
    end

    // R4 set and clear collide
    wclk_err_stb = 1'b1; reg_wr = 1'b1; reg_addr = 1; reg_wdata = 32'h2;
    step();
    rd(0, v); check("R4 set wins on sticky bit", v & 32'h2, 32'h2);
    wr(1, 32'hF);
    in_blk_end = 1'b1; reg_wr = 1'b1; reg_addr = 3; reg_wdata = 32'h11;
    step();
    rd(0, v); check("R4 set wins on event bit", v & 32'h20, 32'h20);

    // R5 R6 R7 capture pointer flow (valid set by the collision write above)
    wr(3, 32'hA5);
    rd(3, v); check("R5 nxt_in readback", v, 32'hA5);
    rd(0, v); check("R7 in event cleared", v, 32'h0);
    pulse_in();
    check("R5 in_ptr loaded", {24'd0, in_ptr_o}, 32'hA5);
    rd(0, v); check("R6 no miss with valid", v, 32'h20);
    pulse_in();
    rd(0, v); check("R6 miss sets bit0", v, 32'h21);
    check("R6 in_ptr kept", {24'd0, in_ptr_o}, 32'hA5);

    // R5 R6 R7 playback pointer flow
    wr(1, 32'h1);
    pulse_out();
    rd(0, v); check("R6 out miss", v, 32'h31);
    check("R6 out_ptr kept", {24'd0, out_ptr_o}, 32'h0);
    wr(4, 32'h13C);
    rd(4, v); check("R5 nxt_out truncated", v, 32'h3C);
    rd(0, v); check("R7 out event cleared", v, 32'h21);
    wr(1, 32'h1);
    pulse_out();
    check("R5 out_ptr loaded", {24'd0, out_ptr_o}, 32'h3C);
    rd(0, v); check("R7 out event set", v, 32'h30);

    // R9 mask sweep with flags = 0x12
    wr(3, 32'h0); wr(4, 32'h0);
    rd(0, v); check("R7 all clear", v, 32'h0);
    wclk_err_stb = 1'b1; out_blk_end = 1'b1;
    step();
    rd(0, v); check("R8 wclk error and out event", v, 32'h12);
    for (int m = 0; m < 64; m++) begin
      wr(2, 32'hFFFF_FFC0 | m);
      rd(2, v); check("R9 mask readback", v, m);
      check("R9 irq", {31'd0, irq_o}, {31'd0, |(m & 6'h12)});
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule